// File: doc/BRIEF.md
# Serial Fuse Program Sequencer

This block performs one 32-bit fuse program operation, or a reload of every fuse word into shadow storage, against a fuse array that is programmed one bit at a time. A register front-end hands it a word address, a data word and a packed word of cycle counts, then pulses a start line. For a program operation the sequencer first reads the addressed fuse word. It clears from the program data every bit whose fuse is already blown, so no fuse is blown twice. It then walks the masked data from bit 0 upward, shifting right with zero fill. Each 1 bit gets a timed program strobe with relax gaps before and after it. Each 0 bit costs a single cycle.

After the last bit, the sequencer holds off for a fixed settling period before it accepts new work. It then raises a one-cycle done pulse. A reload operation reads every word address in ascending order. Each captured word appears on a shadow write port, together with its address.

Every phase length comes from the timing word, measured in clock cycles. A zero field is stretched to one cycle, so no phase ever collapses.

Top module: `fuse_prog_seq`

## Requirements
- R1: After reset, busy, done, both fuse strobes and shadow_we are low.
- R2: A program operation starts with one read of the latched address: relax phase, read strobe held max(SR,1) cycles, relax phase. Exactly one read strobe occurs per program operation.
- R3: A program strobe occurs only for bits that are 1 in the data and 0 in the fuse word read before programming. Afterwards the fuse word equals its old value OR the data.
- R4: Bits are programmed serially in ascending order from bit 0. There is one strobe per programmed bit, and fuse_bit holds that bit's index, unchanged for the whole strobe.
- R5: Each program strobe lasts exactly max(SP,1) cycles.
- R6: Timing word fields are SP in bits [11:0], RELAX in bits [15:12] and SR in bits [21:16]. Each relax phase lasts max(RELAX,1) cycles, and any zero field gives a one-cycle phase.
- R7: With Lr=max(RELAX,1), Lsr=max(SR,1), Lsp=max(SP,1), n ones in the masked data and H the hold-off count, busy stays high for exactly 2Lr+Lsr+32+n(2Lr+Lsp)+H cycles of a program operation.
- R8: The last H busy cycles of a program operation are a quiet hold-off with no strobe. done is a single-cycle pulse in the first cycle after busy falls.
- R9: A reload reads addresses 0 to NUM_WORDS-1 in order. It pulses shadow_we once per word, with shadow_addr and shadow_data matching that word. busy lasts NUM_WORDS(2Lr+Lsr) cycles, followed by a done pulse.
- R10: Start requests made while busy are ignored. When start_prog and start_reload arrive together, the program operation runs and no reload happens.
- R11: The program and read strobes are never high together. During a program operation, fuse_addr stays at the latched address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_prog | input | 1 | Start a program operation (sampled when idle) |
| start_reload | input | 1 | Start a reload of all words (sampled when idle) |
| prog_addr | input | ADDR_W | Word address to program |
| prog_data | input | DATA_W | Bits to program |
| timing_word | input | 22 | Packed phase counts SP, RELAX, SR |
| busy | output | 1 | Operation in progress, including the hold-off |
| done | output | 1 | One-cycle completion pulse |
| fuse_addr | output | ADDR_W | Word address to the fuse array |
| fuse_bit | output | BIT_W | Bit index being programmed |
| fuse_pgm_strobe | output | 1 | Program strobe to the fuse array |
| fuse_rd_strobe | output | 1 | Read strobe to the fuse array |
| fuse_rd_data | input | DATA_W | Word read from the fuse array |
| shadow_we | output | 1 | Shadow write pulse during reload |
| shadow_addr | output | ADDR_W | Shadow word address |
| shadow_data | output | DATA_W | Shadow word value |

## Verification
The bench builds the block with NUM_WORDS of 8 and a hold-off of 20 cycles, keeping DATA_W at 32. With a short array, a full reload and its address walk end in a few hundred cycles. The short hold-off lets the exact busy-length formula be checked across many timing words: all fields zero, mid values, and the largest relax and read counts. The bench also uses a long program strobe on a sparse data word, and a data word that overlaps bits already blown.

// File: rtl/fps_pkg.sv
package fps_pkg;

    // Field layout of the packed timing word
    localparam int SP_LSB   = 0;
    localparam int SP_W     = 12;
    localparam int RX_LSB   = 12;
    localparam int RX_W     = 4;
    localparam int SR_LSB   = 16;
    localparam int SR_W     = 6;
    localparam int TIMING_W = SR_LSB + SR_W;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_SETUP,
        ST_RD_STROBE,
        ST_RD_HOLD,
        ST_PG_BIT,
        ST_PG_SETUP,
        ST_PG_STROBE,
        ST_PG_HOLD,
        ST_HOLDOFF
    } seq_state_e;

    // Phase lengths after the zero-to-one floor has been applied
    typedef struct packed {
        logic [SP_W-1:0] prog_len;
        logic [RX_W-1:0] relax_len;
        logic [SR_W-1:0] read_len;
    } phase_len_t;

endpackage

// File: rtl/fps_timing_unpack.sv
module fps_timing_unpack
    import fps_pkg::*;
(
    input  logic [TIMING_W-1:0] timing_word,
    output phase_len_t          lens
);
    logic [SP_W-1:0] sp_raw;
    logic [RX_W-1:0] rx_raw;
    logic [SR_W-1:0] sr_raw;

    always_comb begin
        sp_raw = timing_word[SP_LSB +: SP_W];
        rx_raw = timing_word[RX_LSB +: RX_W];
        sr_raw = timing_word[SR_LSB +: SR_W];
        // A zero count still occupies one cycle
        lens.prog_len  = (sp_raw == '0) ? SP_W'(1) : sp_raw;
        lens.relax_len = (rx_raw == '0) ? RX_W'(1) : rx_raw;
        lens.read_len  = (sr_raw == '0) ? SR_W'(1) : sr_raw;
    end
endmodule

// File: rtl/fps_phase_timer.sv
module fps_phase_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_len,
    output logic             last
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_len - CNT_W'(1);
        else if (cnt_q != '0)
            cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == '0);

    // R6: every phase is loaded with at least one cycle
    a_r6_len_floor: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_len != '0));
endmodule

// File: rtl/fps_shift_reg.sv
module fps_shift_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift_en,
    output logic         lsb
);
    logic [W-1:0] data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (load)
            data_d = load_val;
        else if (shift_en)
            data_d = {1'b0, data_q[W-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end

    assign lsb = data_q[0];

    // R4: shifting fills the top with zero
    a_r4_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !load) |=> (data_q[W-1] == 1'b0));
endmodule

// File: rtl/fuse_prog_seq.sv
module fuse_prog_seq
    import fps_pkg::*;
#(
    parameter int  DATA_W      = 32,
    parameter int  NUM_WORDS   = 128,
    parameter int  HOLDOFF_CYC = 200,
    localparam int ADDR_W      = $clog2(NUM_WORDS),
    localparam int BIT_W       = $clog2(DATA_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_prog,
    input  logic                start_reload,
    input  logic [ADDR_W-1:0]   prog_addr,
    input  logic [DATA_W-1:0]   prog_data,
    input  logic [TIMING_W-1:0] timing_word,
    output logic                busy,
    output logic                done,
    output logic [ADDR_W-1:0]   fuse_addr,
    output logic [BIT_W-1:0]    fuse_bit,
    output logic                fuse_pgm_strobe,
    output logic                fuse_rd_strobe,
    input  logic [DATA_W-1:0]   fuse_rd_data,
    output logic                shadow_we,
    output logic [ADDR_W-1:0]   shadow_addr,
    output logic [DATA_W-1:0]   shadow_data
);
    localparam int HOLD_W = $clog2(HOLDOFF_CYC + 1);
    localparam int CNT_W  = (HOLD_W > SP_W) ? HOLD_W : SP_W;
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_WORDS - 1);
    localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(DATA_W - 1);

    typedef struct packed {
        seq_state_e        state;
        logic              prog_mode;
        logic [ADDR_W-1:0] addr;
        logic [BIT_W-1:0]  bit_idx;
        logic [DATA_W-1:0] raw;
        phase_len_t        lens;
        logic              done;
        logic              sh_we;
        logic [DATA_W-1:0] sh_data;
    } ctl_t;

    ctl_t c_q, c_d;

    phase_len_t        in_lens;
    logic              tmr_load, tmr_last;
    logic [CNT_W-1:0]  tmr_len;
    logic              sh_load, sh_shift, sh_lsb;
    logic [DATA_W-1:0] sh_val;

    fps_timing_unpack u_unpack (
        .timing_word (timing_word),
        .lens        (in_lens)
    );

    fps_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_len (tmr_len),
        .last     (tmr_last)
    );

    fps_shift_reg #(.W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .load_val (sh_val),
        .shift_en (sh_shift),
        .lsb      (sh_lsb)
    );

    always_comb begin
        c_d       = c_q;
        c_d.done  = 1'b0;
        c_d.sh_we = 1'b0;
        tmr_load  = 1'b0;
        tmr_len   = '0;
        sh_load   = 1'b0;
        sh_shift  = 1'b0;
        // Drop bits whose fuse is already blown
        sh_val    = c_q.raw & ~fuse_rd_data;

        unique case (c_q.state)
            ST_IDLE: begin
                if (start_prog) begin
                    c_d.state     = ST_RD_SETUP;
                    c_d.prog_mode = 1'b1;
                    c_d.addr      = prog_addr;
                    c_d.raw       = prog_data;
                    c_d.lens      = in_lens;
                    tmr_load      = 1'b1;
                    tmr_len       = CNT_W'(in_lens.relax_len);
                end else if (start_reload) begin
                    c_d.state     = ST_RD_SETUP;
                    c_d.prog_mode = 1'b0;
                    c_d.addr      = '0;
                    c_d.lens      = in_lens;
                    tmr_load      = 1'b1;
                    tmr_len       = CNT_W'(in_lens.relax_len);
                end
            end
            ST_RD_SETUP: begin
                if (tmr_last) begin
                    c_d.state = ST_RD_STROBE;
                    tmr_load  = 1'b1;
                    tmr_len   = CNT_W'(c_q.lens.read_len);
                end
            end
            ST_RD_STROBE: begin
                if (tmr_last) begin
                    if (c_q.prog_mode) begin
                        sh_load = 1'b1;
                    end else begin
                        c_d.sh_we   = 1'b1;
                        c_d.sh_data = fuse_rd_data;
                    end
                    c_d.state = ST_RD_HOLD;
                    tmr_load  = 1'b1;
                    tmr_len   = CNT_W'(c_q.lens.relax_len);
                end
            end
            ST_RD_HOLD: begin
                if (tmr_last) begin
                    if (c_q.prog_mode) begin
                        c_d.state   = ST_PG_BIT;
                        c_d.bit_idx = '0;
                    end else if (c_q.addr == LAST_ADDR) begin
                        c_d.state = ST_IDLE;
                        c_d.done  = 1'b1;
                    end else begin
                        c_d.addr  = c_q.addr + ADDR_W'(1);
                        c_d.state = ST_RD_SETUP;
                        tmr_load  = 1'b1;
                        tmr_len   = CNT_W'(c_q.lens.relax_len);
                    end
                end
            end
            ST_PG_BIT: begin
                if (sh_lsb) begin
                    c_d.state = ST_PG_SETUP;
                    tmr_load  = 1'b1;
                    tmr_len   = CNT_W'(c_q.lens.relax_len);
                end else begin
                    sh_shift = 1'b1;
                    if (c_q.bit_idx == LAST_BIT) begin
                        c_d.state = ST_HOLDOFF;
                        tmr_load  = 1'b1;
                        tmr_len   = CNT_W'(HOLDOFF_CYC);
                    end else begin
                        c_d.bit_idx = c_q.bit_idx + BIT_W'(1);
                    end
                end
            end
            ST_PG_SETUP: begin
                if (tmr_last) begin
                    c_d.state = ST_PG_STROBE;
                    tmr_load  = 1'b1;
                    tmr_len   = CNT_W'(c_q.lens.prog_len);
                end
            end
            ST_PG_STROBE: begin
                if (tmr_last) begin
                    c_d.state = ST_PG_HOLD;
                    tmr_load  = 1'b1;
                    tmr_len   = CNT_W'(c_q.lens.relax_len);
                end
            end
            ST_PG_HOLD: begin
                if (tmr_last) begin
                    sh_shift = 1'b1;
                    if (c_q.bit_idx == LAST_BIT) begin
                        c_d.state = ST_HOLDOFF;
                        tmr_load  = 1'b1;
                        tmr_len   = CNT_W'(HOLDOFF_CYC);
                    end else begin
                        c_d.state   = ST_PG_BIT;
                        c_d.bit_idx = c_q.bit_idx + BIT_W'(1);
                    end
                end
            end
            ST_HOLDOFF: begin
                if (tmr_last) begin
                    c_d.state = ST_IDLE;
                    c_d.done  = 1'b1;
                end
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign busy            = (c_q.state != ST_IDLE);
    assign done            = c_q.done;
    assign fuse_addr       = c_q.addr;
    assign fuse_bit        = c_q.bit_idx;
    assign fuse_pgm_strobe = (c_q.state == ST_PG_STROBE);
    assign fuse_rd_strobe  = (c_q.state == ST_RD_STROBE);
    assign shadow_we       = c_q.sh_we;
    assign shadow_addr     = c_q.addr;
    assign shadow_data     = c_q.sh_data;

    // R11: the two strobes never overlap
    a_r11_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(fuse_pgm_strobe && fuse_rd_strobe));

    // R11: address held for the whole program operation
    a_r11_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && c_q.prog_mode) |-> $stable(fuse_addr));

    // R4: bit index does not move while a strobe is applied
    a_r4_bit_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (fuse_pgm_strobe && $past(fuse_pgm_strobe)) |-> $stable(fuse_bit));

    // R8: done only once the block is no longer busy
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R10: a start while busy cannot end or restart the operation early
    a_r10_busy_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tmr_last && (start_prog || start_reload)) |=> busy);

    // R9: shadow writes belong to reload operations only
    a_r9_shadow_reload: assert property (@(posedge clk) disable iff (!rst_n)
        shadow_we |-> !c_q.prog_mode);

    // R8: the hold-off phase is quiet
    a_r8_quiet_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == ST_HOLDOFF) |-> !(fuse_pgm_strobe || fuse_rd_strobe));
endmodule

// File: tb/fuse_prog_seq_tb_top.sv
module fuse_prog_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NW   = 8;
    localparam int HOLD = 20;
    localparam int AW   = $clog2(NW);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_prog = 1'b0, start_reload = 1'b0;
    logic [AW-1:0] prog_addr = '0;
    logic [31:0] prog_data = '0;
    logic [21:0] timing_word = '0;
    logic        busy, done, fuse_pgm_strobe, fuse_rd_strobe, shadow_we;
    logic [AW-1:0] fuse_addr, shadow_addr;
    logic [4:0]  fuse_bit;
    logic [31:0] fuse_rd_data, shadow_data;

    logic [31:0] fuse_mem [NW];

    int n_checks = 0, n_errors = 0;
    int busy_cyc, done_cnt, pg_cnt, rd_cnt, sh_cnt, pg_run, rd_run, last_bit, exp_sh_addr;
    int exp_lsp, exp_lsr;
    logic [31:0] exp_mask;
    logic [AW-1:0] exp_addr;
    logic pg_prev = 1'b0, rd_prev = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign fuse_rd_data = fuse_mem[fuse_addr];

    fuse_prog_seq #(.DATA_W(32), .NUM_WORDS(NW), .HOLDOFF_CYC(HOLD)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_prog(start_prog), .start_reload(start_reload),
        .prog_addr(prog_addr), .prog_data(prog_data), .timing_word(timing_word),
        .busy(busy), .done(done), .fuse_addr(fuse_addr), .fuse_bit(fuse_bit),
        .fuse_pgm_strobe(fuse_pgm_strobe), .fuse_rd_strobe(fuse_rd_strobe),
        .fuse_rd_data(fuse_rd_data), .shadow_we(shadow_we),
        .shadow_addr(shadow_addr), .shadow_data(shadow_data));

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int floor1(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    // Fuse array model and protocol monitor, sampled on the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) busy_cyc++;
            if (done) done_cnt++;
            if (fuse_pgm_strobe && fuse_rd_strobe)
                check(1'b0, "R11", "strobes overlap", 1, 0);
            if (shadow_we) begin
                sh_cnt++;
                check(int'(shadow_addr) == exp_sh_addr, "R9", "shadow address order",
                      shadow_addr, exp_sh_addr);
                check(shadow_data == fuse_mem[shadow_addr], "R9", "shadow data",
                      shadow_data, fuse_mem[shadow_addr]);
                exp_sh_addr++;
            end
            if (fuse_pgm_strobe) begin
                if (!pg_prev) begin
                    pg_cnt++;
                    check(int'(fuse_bit) > last_bit, "R4", "ascending bit order",
                          fuse_bit, last_bit + 1);
                    check(exp_mask[fuse_bit] == 1'b1, "R3", "strobe on masked-off bit",
                          fuse_bit, -1);
                    check(fuse_addr == exp_addr, "R11", "program address", fuse_addr, exp_addr);
                    last_bit = int'(fuse_bit);
                end
                pg_run++;
            end else if (pg_prev) begin
                check(pg_run == exp_lsp, "R5", "program strobe length", pg_run, exp_lsp);
                fuse_mem[fuse_addr][last_bit] = 1'b1;
                pg_run = 0;
            end
            if (fuse_rd_strobe) begin
                if (!rd_prev) rd_cnt++;
                rd_run++;
            end else if (rd_prev) begin
                check(rd_run == exp_lsr, "R2", "read strobe length", rd_run, exp_lsr);
                rd_run = 0;
            end
            pg_prev = fuse_pgm_strobe;
            rd_prev = fuse_rd_strobe;
        end
    end

    task automatic clear_counts();
        busy_cyc = 0; done_cnt = 0; pg_cnt = 0; rd_cnt = 0; sh_cnt = 0;
        pg_run = 0; rd_run = 0; last_bit = -1; exp_sh_addr = 0;
    endtask

    task automatic wait_done();
        bit seen = 1'b0;
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk);
            if (done) begin seen = 1'b1; break; end
        end
        if (!seen) check(1'b0, "WDOG", "operation never finished", 0, 1);
        repeat (3) @(negedge clk);
    endtask

    // Runs one program operation; optional stray starts while busy (R10)
    task automatic run_prog(input logic [AW-1:0] a, input logic [31:0] d,
                            input logic [21:0] tw, input bit with_reload, input bit stray);
        logic [31:0] old, mask;
        logic [AW-1:0] other;
        logic [31:0] other_old;
        int lr, lsr, lsp, n1, exp_busy;
        lsp = floor1(int'(tw[11:0]));
        lr  = floor1(int'(tw[15:12]));
        lsr = floor1(int'(tw[21:16]));
        old = fuse_mem[a];
        mask = d & ~old;
        n1 = $countones(mask);
        exp_busy = 2*lr + lsr + 32 + n1*(2*lr + lsp) + HOLD;
        other = a + AW'(1);
        other_old = fuse_mem[other];
        exp_lsp = lsp; exp_lsr = lsr; exp_mask = mask; exp_addr = a;
        @(negedge clk);
        clear_counts();
        prog_addr = a; prog_data = d; timing_word = tw;
        start_prog = 1'b1; start_reload = with_reload;
        @(negedge clk);
        start_prog = 1'b0; start_reload = 1'b0;
        if (stray) begin
            repeat (4) @(negedge clk);
            prog_addr = other; prog_data = 32'hFFFF_FFFF;
            start_prog = 1'b1; start_reload = 1'b1;
            @(negedge clk);
            start_prog = 1'b0; start_reload = 1'b0;
        end
        wait_done();
        check(busy_cyc == exp_busy, "R7", "program busy length", busy_cyc, exp_busy);
        check(pg_cnt == n1, "R3", "program strobe count", pg_cnt, n1);
        check(fuse_mem[a] == (old | d), "R3", "fuse word after program", fuse_mem[a], old | d);
        check(rd_cnt == 1, "R2", "pre-read count", rd_cnt, 1);
        check(done_cnt == 1, "R8", "done pulse count", done_cnt, 1);
        check(busy == 1'b0, "R8", "idle after done", busy, 0);
        if (with_reload || stray)
            check(sh_cnt == 0, "R10", "no reload ran", sh_cnt, 0);
        if (stray)
            check(fuse_mem[other] == other_old, "R10", "stray address untouched",
                  fuse_mem[other], other_old);
    endtask

    task automatic t_reset();
        check(busy == 0 && done == 0, "R1", "busy/done at reset", {busy, done}, 0);
        check(fuse_pgm_strobe == 0 && fuse_rd_strobe == 0, "R1", "strobes at reset",
              {fuse_pgm_strobe, fuse_rd_strobe}, 0);
        check(shadow_we == 0, "R1", "shadow_we at reset", shadow_we, 0);
    endtask

    task automatic t_holdoff_quiet();
        // R8: hold-off cycles are part of busy, checked through the R7 length
        run_prog(3'd6, 32'h0000_0000, {6'd2, 4'd1, 12'd3}, 1'b0, 1'b0);
    endtask

    task automatic t_reload(input logic [21:0] tw);
        int lr, lsr, exp_busy;
        lr  = floor1(int'(tw[15:12]));
        lsr = floor1(int'(tw[21:16]));
        exp_busy = NW * (2*lr + lsr);
        exp_lsr = lsr;
        @(negedge clk);
        clear_counts();
        timing_word = tw;
        start_reload = 1'b1;
        @(negedge clk);
        start_reload = 1'b0;
        wait_done();
        check(sh_cnt == NW, "R9", "shadow write count", sh_cnt, NW);
        check(busy_cyc == exp_busy, "R9", "reload busy length", busy_cyc, exp_busy);
        check(done_cnt == 1, "R9", "reload done pulse", done_cnt, 1);
        check(pg_cnt == 0, "R9", "no program strobe in reload", pg_cnt, 0);
    endtask

    initial begin
        for (int i = 0; i < NW; i++) fuse_mem[i] = 32'h0;
        fuse_mem[5] = 32'h0000_0030;
        fuse_mem[7] = 32'hA5A5_0001;
        clear_counts();
        exp_mask = '0; exp_addr = '0; exp_lsp = 1; exp_lsr = 1;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        // R4/R5/R6: mid-range fields, bits 0 and 31
        run_prog(3'd3, 32'h8000_0001, {6'd3, 4'd2, 12'd5}, 1'b0, 1'b0);
        // R3: overlapping data, only fresh bits strobed
        run_prog(3'd3, 32'hFFFF_0003, {6'd3, 4'd2, 12'd5}, 1'b0, 1'b0);
        // R6: every field zero gives one-cycle phases
        run_prog(3'd5, 32'h0000_00F0, 22'h0, 1'b0, 1'b0);
        // R5/R6: long strobe, largest relax and read counts
        run_prog(3'd1, 32'h0000_0004, {6'd63, 4'd15, 12'd300}, 1'b0, 1'b0);
        // R8: empty data, quiet hold-off
        t_holdoff_quiet();
        // R9: reload of all words
        t_reload({6'd4, 4'd3, 12'd7});
        t_reload(22'h0);
        // R10: stray starts while busy, then simultaneous starts
        run_prog(3'd2, 32'h0F00_00F0, {6'd2, 4'd1, 12'd4}, 1'b0, 1'b1);
        run_prog(3'd4, 32'h1234_5678, {6'd1, 4'd1, 12'd2}, 1'b1, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        n_checks++;
        n_errors++;
        $display("FAIL WDOG global timeout: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule